// File: doc/BRIEF.md
# Hibernate Wake-Up Controller

This block lives in the always-powered domain of a chip and manages entry into and exit from a deep low-power state. Software writes a request bit in the control register. The controller then moves the selected regulator-control pad to its "supply off" level. From then on it watches a set of wake sources, each with its own enable:

- a real-time-clock event,
- a clock-oscillator watchdog event,
- a rising or a falling edge on one selectable digital pad,
- low and high threshold flags from three comparator channels (two analog pins and the battery supply).

The first enabled event in the hibernate state returns the control pad to its "supply on" level. No software action is needed for this.

Two supply schemes are supported. In the external scheme, the pad drives an off-chip regulator enable. In the internal scheme, the controller also holds an active-low core reset and switches off the reset-pin pull-up while hibernating. On wake, the pull-up is turned back on, and the reset is released only once the core supply reports good.

Every enabled event sets a sticky cause bit, whatever the state. A wake-from-hibernate flag and a lock-up-risk flag are kept next to the cause bits. All of these flags are cleared by writing ones to a separate clear register.

Each pad has two settings of its own: a polarity bit that gives its hibernate level, and a drive-mode field. After reset, pad 0 is open-drain driving low and pad 1 is high-impedance. Pad 0 can be the regulator control and the falling-edge wake input at the same time. An outside driver that pulls it low is seen as a wake edge.

Top module: `hib_wake_ctrl`

## Requirements
- R1: After reset, the control register reads 0x090 (pad 0 polarity 1, pad 0 mode open-drain, pad 1 mode high-impedance, everything else 0). The status register reads 0, `pad_out` is 2'b10, `pad_mode` is 4'b0010, and `core_rst_n` and `rst_pu_en` are both 1.
- R2: A write to address 0 with bit 0 set, made while the controller is active, moves the controller out of the active state on the next clock edge. From that edge on, the control pad shows its hibernate level.
- R3: In hibernate, an enabled wake event moves the controller to waking on the next edge. The control pad returns to its non-hibernate level with no register access.
- R4: An event whose enable bit (address 1) is 0 neither sets its status bit nor wakes the controller. Enable and cause bit positions are: 0 clock event, 1 oscillator watchdog, 2 digital rising edge, 3 digital falling edge, 4+2k comparator k low, 5+2k comparator k high.
- R5: Digital wake edges are taken only from the pad named by control bit 2. Rising and falling detection each follow their own enable bit.
- R6: With pad 0 as both the control pad and the falling-edge source, an outside low level on pad 0 during hibernate wakes the controller and sets cause bit 3.
- R7: Control bit 4+i is pad i's hibernate level. A pad shows the inverse of that level whenever it is not the hibernating control pad (control bit 3 selects the control pad). Control bits 6+2i..7+2i drive `pad_mode` bits 2i..2i+1 (00 high-impedance, 01 push-pull, 10 open-drain).
- R8: With control bit 1 set (internal scheme), `core_rst_n` is 0 and `rst_pu_en` is 0 from entry through hibernate. In waking, `rst_pu_en` is 1, and `core_rst_n` stays 0 until `core_pwr_ok` is 1.
- R9: Cause bits in status (address 2) are sticky and are cleared by writing 1 to the same bit of address 3. A set and a clear in the same cycle leave the bit set.
- R10: Status bit CAUSE_W (bit 10 by default) is set when hibernate is left. It is cleared only by writing 1 to that bit of address 3.
- R11: A hibernate request accepted while all enable bits are 0 sets status bit CAUSE_W+1 (bit 11 by default), which is cleared the same way.
- R12: Enabled events in the active state update status but never change the state or the pads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low domain reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 enable, 2 status, 3 clear) |
| reg_wdata | input | CAUSE_W+2 | Write data |
| reg_rdata | output | CAUSE_W+2 | Read data for `reg_addr` |
| rtc_evt | input | 1 | Real-time-clock event pulse |
| oscwd_evt | input | 1 | Oscillator watchdog event pulse |
| cmp_lo | input | NUM_CMP | Comparator below-threshold flags |
| cmp_hi | input | NUM_CMP | Comparator above-threshold flags |
| pad_in | input | 2 | Asynchronous pad input levels |
| core_pwr_ok | input | 1 | Core supply good indication |
| pad_out | output | 2 | Pad output values |
| pad_mode | output | 4 | Pad drive modes, 2 bits per pad |
| core_rst_n | output | 1 | Active-low core reset |
| rst_pu_en | output | 1 | Reset-pin pull-up enable |

## Verification
A cause flag can be set by a source event and cleared by a write to the clear register in the same cycle. The bench provokes this by raising the clock event and issuing the clear write in the same cycle. It then reads status and expects the bit still set, and a later clear on its own must remove it.

A second collision is checked under random stimulus: enable masks and event patterns applied while active. Each result is compared with a bench function of mask and events, and the pads must not change.

// File: rtl/hib_pkg.sv
package hib_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_ENTER  = 2'd1,
    ST_HIB    = 2'd2,
    ST_WAKE   = 2'd3
  } hib_state_e;

  typedef enum logic [1:0] {
    DRV_HIZ = 2'b00,
    DRV_PP  = 2'b01,
    DRV_OD  = 2'b10
  } drv_mode_e;

  localparam int NUM_PIN = 2;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_WEN  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CLR  = 2'd3;

  // control register bit positions
  localparam int CB_REQ   = 0;
  localparam int CB_INT   = 1;
  localparam int CB_WSEL  = 2;
  localparam int CB_CSEL  = 3;
  localparam int CB_POL   = 4;
  localparam int CB_MODE  = 6;
  localparam int CTRL_W   = CB_MODE + 2 * NUM_PIN;

  // cause vector positions
  localparam int EV_RTC   = 0;
  localparam int EV_OSC   = 1;
  localparam int EV_RISE  = 2;
  localparam int EV_FALL  = 3;
  localparam int EV_CMP0  = 4;

  localparam logic [NUM_PIN-1:0] RST_POL = 2'b01;
endpackage

// File: rtl/hib_pin_sync.sv
module hib_pin_sync #(
  parameter int NPIN   = 2,
  parameter int STAGES = 2,
  localparam int SEL_W = (NPIN > 1) ? $clog2(NPIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pad_in,
  input  logic [SEL_W-1:0] sel,
  output logic             rise,
  output logic             fall
);
  logic [NPIN-1:0] synced;
  logic [NPIN-1:0] prev_q;

  for (genvar gp = 0; gp < NPIN; gp++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q    <= '0;
        prev_q[gp] <= 1'b0;
      end else begin
        chain_q    <= {chain_q[STAGES-2:0], pad_in[gp]};
        prev_q[gp] <= chain_q[STAGES-1];
      end
    end
    assign synced[gp] = chain_q[STAGES-1];
  end

  assign rise = synced[sel] & ~prev_q[sel];
  assign fall = ~synced[sel] & prev_q[sel];
endmodule

// File: rtl/hib_cause_reg.sv
module hib_cause_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags_q
);
  logic [W-1:0] flags_d;
  logic         upd;

  always_comb begin
    flags_d = (flags_q & ~clr_vec) | set_vec;
    upd     = |{set_vec, clr_vec};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end
endmodule

// File: rtl/hib_fsm.sv
module hib_fsm
  import hib_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_fire,
  input  logic       wake_hit,
  input  logic       internal_mode,
  input  logic       core_pwr_ok,
  output hib_state_e state_q,
  output logic       hib_on,
  output logic       woke_set,
  output logic       core_rst_n,
  output logic       rst_pu_en
);
  hib_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: if (req_fire) state_d = ST_ENTER;
      ST_ENTER:  state_d = ST_HIB;
      ST_HIB:    if (wake_hit) state_d = ST_WAKE;
      ST_WAKE:   if (!internal_mode || core_pwr_ok) state_d = ST_ACTIVE;
      default:   state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_ACTIVE;
    else        state_q <= state_d;
  end

  always_comb begin
    hib_on     = (state_q == ST_ENTER) || (state_q == ST_HIB);
    woke_set   = (state_q == ST_HIB) && wake_hit;
    core_rst_n = !(internal_mode && (state_q != ST_ACTIVE));
    rst_pu_en  = !(internal_mode && hib_on);
  end
endmodule

// File: rtl/hib_wake_ctrl.sv
module hib_wake_ctrl
  import hib_pkg::*;
#(
  parameter int NUM_CMP     = 3,
  parameter int SYNC_STAGES = 2,
  localparam int CAUSE_W    = 4 + 2 * NUM_CMP,
  localparam int DATA_W     = CAUSE_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic                 rtc_evt,
  input  logic                 oscwd_evt,
  input  logic [NUM_CMP-1:0]   cmp_lo,
  input  logic [NUM_CMP-1:0]   cmp_hi,
  input  logic [NUM_PIN-1:0]   pad_in,
  input  logic                 core_pwr_ok,
  output logic [NUM_PIN-1:0]   pad_out,
  output logic [2*NUM_PIN-1:0] pad_mode,
  output logic                 core_rst_n,
  output logic                 rst_pu_en
);
  localparam int SEL_W = $clog2(NUM_PIN);

  // control fields
  logic                          internal_q;
  logic [SEL_W-1:0]              wsel_q;
  logic [SEL_W-1:0]              csel_q;
  logic [NUM_PIN-1:0]            pol_q;
  logic [NUM_PIN-1:0][1:0]       mode_q;
  logic [CAUSE_W-1:0]            wen_q;
  logic [CAUSE_W-1:0]            cause_q;
  logic [1:0]                    flag_q;   // [0] woke, [1] lock-up risk

  logic wr_ctrl, wr_wen, wr_clr;
  logic req_fire, wake_hit, woke_set, hib_on;
  logic dig_rise, dig_fall;
  logic [CAUSE_W-1:0] evt_vec;
  logic [CAUSE_W-1:0] cause_set;
  logic [CAUSE_W-1:0] clr_mask;
  logic [1:0]         flag_set;
  logic [1:0]         flag_clr;
  hib_state_e         state_w;

  always_comb begin
    wr_ctrl = reg_we && (reg_addr == ADDR_CTRL);
    wr_wen  = reg_we && (reg_addr == ADDR_WEN);
    wr_clr  = reg_we && (reg_addr == ADDR_CLR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      internal_q <= 1'b0;
      wsel_q     <= '0;
      csel_q     <= '0;
      pol_q      <= RST_POL;
      mode_q[0]  <= DRV_OD;
      mode_q[1]  <= DRV_HIZ;
    end else if (wr_ctrl) begin
      internal_q <= reg_wdata[CB_INT];
      wsel_q     <= reg_wdata[CB_WSEL +: SEL_W];
      csel_q     <= reg_wdata[CB_CSEL +: SEL_W];
      pol_q      <= reg_wdata[CB_POL +: NUM_PIN];
      mode_q     <= reg_wdata[CB_MODE +: 2*NUM_PIN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wen_q <= '0;
    else if (wr_wen) wen_q <= reg_wdata[CAUSE_W-1:0];
  end

  // synchronized digital wake edge
  hib_pin_sync #(.NPIN(NUM_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .sel    (wsel_q),
    .rise   (dig_rise),
    .fall   (dig_fall)
  );

  assign evt_vec[EV_RTC]  = rtc_evt;
  assign evt_vec[EV_OSC]  = oscwd_evt;
  assign evt_vec[EV_RISE] = dig_rise;
  assign evt_vec[EV_FALL] = dig_fall;
  for (genvar gc = 0; gc < NUM_CMP; gc++) begin : g_cmp
    assign evt_vec[EV_CMP0 + 2*gc]     = cmp_lo[gc];
    assign evt_vec[EV_CMP0 + 2*gc + 1] = cmp_hi[gc];
  end

  always_comb begin
    cause_set = evt_vec & wen_q;
    wake_hit  = |cause_set;
    req_fire  = wr_ctrl && reg_wdata[CB_REQ] && (state_w == ST_ACTIVE);
    clr_mask  = wr_clr ? reg_wdata[CAUSE_W-1:0] : '0;
    flag_set  = {req_fire && (wen_q == '0), woke_set};
    flag_clr  = wr_clr ? reg_wdata[CAUSE_W +: 2] : 2'b00;
  end

  hib_cause_reg #(.W(CAUSE_W)) u_cause (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (cause_set),
    .clr_vec (clr_mask),
    .flags_q (cause_q)
  );

  hib_cause_reg #(.W(2)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (flag_set),
    .clr_vec (flag_clr),
    .flags_q (flag_q)
  );

  hib_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_fire      (req_fire),
    .wake_hit      (wake_hit),
    .internal_mode (internal_q),
    .core_pwr_ok   (core_pwr_ok),
    .state_q       (state_w),
    .hib_on        (hib_on),
    .woke_set      (woke_set),
    .core_rst_n    (core_rst_n),
    .rst_pu_en     (rst_pu_en)
  );

  for (genvar gi = 0; gi < NUM_PIN; gi++) begin : g_pad
    assign pad_out[gi] = (hib_on && (csel_q == SEL_W'(gi))) ? pol_q[gi] : ~pol_q[gi];
    assign pad_mode[2*gi +: 2] = mode_q[gi];
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = DATA_W'({mode_q, pol_q, csel_q, wsel_q, internal_q, 1'b0});
      ADDR_WEN:  reg_rdata = DATA_W'(wen_q);
      ADDR_STAT: reg_rdata = {flag_q, cause_q};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hib_wake_ctrl_chk.sv
module hib_wake_ctrl_chk
  import hib_pkg::*;
#(
  parameter int CAUSE_W = 10
) (
  input logic               clk,
  input logic               rst_n,
  input hib_state_e         state,
  input logic               req_fire,
  input logic               wake_hit,
  input logic               internal_mode,
  input logic               core_pwr_ok,
  input logic               core_rst_n,
  input logic               rst_pu_en,
  input logic [CAUSE_W-1:0] cause_q,
  input logic [CAUSE_W-1:0] clr_mask
);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && req_fire) |=> (state == ST_ENTER));

  p_wake_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIB && wake_hit) |=> (state == ST_WAKE));

  p_rst_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAKE && internal_mode && !core_pwr_ok) |-> !core_rst_n);

  p_pu_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HIB && internal_mode) |-> !rst_pu_en);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == state) |=> ((($past(cause_q) & ~$past(clr_mask)) & ~cause_q) == '0));

  p_stay_active_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ACTIVE && !req_fire) |=> (state == ST_ACTIVE));
endmodule

bind hib_wake_ctrl hib_wake_ctrl_chk #(.CAUSE_W(CAUSE_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .state         (state_w),
  .req_fire      (req_fire),
  .wake_hit      (wake_hit),
  .internal_mode (internal_q),
  .core_pwr_ok   (core_pwr_ok),
  .core_rst_n    (core_rst_n),
  .rst_pu_en     (rst_pu_en),
  .cause_q       (cause_q),
  .clr_mask      (clr_mask)
);

// File: tb/hib_wake_ctrl_tb.sv
module hib_wake_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_we;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          rtc_evt, oscwd_evt;
  logic [2:0]    cmp_lo, cmp_hi;
  logic [1:0]    pad_in;
  logic          core_pwr_ok;
  logic [1:0]    pad_out;
  logic [3:0]    pad_mode;
  logic          core_rst_n, rst_pu_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hib_wake_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rtc_evt(rtc_evt),
    .oscwd_evt(oscwd_evt), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .pad_in(pad_in),
    .core_pwr_ok(core_pwr_ok), .pad_out(pad_out), .pad_mode(pad_mode),
    .core_rst_n(core_rst_n), .rst_pu_en(rst_pu_en)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected cause bits for non-digital events under an enable mask
  function automatic logic [DW-1:0] exp_cause(input logic [9:0] en, input logic r,
                                              input logic o, input logic [2:0] lo,
                                              input logic [2:0] hi);
    logic [9:0] ev;
    ev = {hi[2], lo[2], hi[1], lo[1], hi[0], lo[0], 2'b00, o, r};
    return DW'(ev & en);
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd7321));
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    rtc_evt = 1'b0; oscwd_evt = 1'b0; cmp_lo = '0; cmp_hi = '0;
    pad_in = 2'b00; core_pwr_ok = 1'b1;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 12'h090);
    rd(2'd2, d); check("R1 status", d, 0);
    check("R1 pad_out", pad_out, 2'b10);
    check("R1 pad_mode", pad_mode, 4'b0010);
    check("R1 core_rst_n", core_rst_n, 1);
    check("R1 rst_pu_en", rst_pu_en, 1);

    pad_in = 2'b11;   // pull-ups, no edge enable yet
    idle(5);

    // R4 / R12 random events while active
    for (int it = 0; it < 24; it++) begin
      logic [9:0] en;
      logic r, o;
      logic [2:0] lo, hi;
      en = 10'($urandom);
      r = 1'($urandom); o = 1'($urandom);
      lo = 3'($urandom); hi = 3'($urandom);
      wr(2'd3, 12'hFFF);
      wr(2'd1, {2'b00, en});
      @(negedge clk);
      rtc_evt = r; oscwd_evt = o; cmp_lo = lo; cmp_hi = hi;
      @(negedge clk);
      rtc_evt = 0; oscwd_evt = 0; cmp_lo = 0; cmp_hi = 0;
      rd(2'd2, d);
      check("R4 random cause", d, exp_cause(en, r, o, lo, hi));
      check("R12 pads unchanged", pad_out, 2'b10);
    end

    // R9 sticky and set-beats-clear
    wr(2'd3, 12'hFFF);
    wr(2'd1, 12'h001);
    @(negedge clk); rtc_evt = 1; @(negedge clk); rtc_evt = 0;
    idle(3);
    rd(2'd2, d); check("R9 sticky", d, 12'h001);
    @(negedge clk);
    rtc_evt = 1; reg_we = 1; reg_addr = 2'd3; reg_wdata = 12'h001;
    @(negedge clk);
    rtc_evt = 0; reg_we = 0;
    rd(2'd2, d); check("R9 set wins", d, 12'h001);
    wr(2'd3, 12'h001);
    rd(2'd2, d); check("R9 w1c", d, 0);

    // R11 lock-up, R2, R4 in hibernate, R3, R10 (external scheme, pad 0)
    wr(2'd1, 12'h000);
    wr(2'd0, 12'h091);
    check("R2 pad0 hib level", pad_out[0], 1);
    rd(2'd2, d); check("R11 lockup", d, 12'h800);
    wr(2'd1, 12'h001);
    @(negedge clk); oscwd_evt = 1; @(negedge clk); oscwd_evt = 0;
    idle(2);
    check("R4 disabled no wake", pad_out[0], 1);
    rd(2'd2, d); check("R4 disabled no cause", d, 12'h800);
    @(negedge clk); rtc_evt = 1; @(negedge clk); rtc_evt = 0;
    check("R3 auto wake", pad_out[0], 0);
    rd(2'd2, d); check("R10 woke flag", d, 12'hC01);
    wr(2'd3, 12'h400);
    rd(2'd2, d); check("R10 woke clear", d, 12'h801);
    wr(2'd3, 12'hFFF);

    // R5 / R6 falling edge on pad 0
    wr(2'd1, 12'h008);
    wr(2'd0, 12'h091);
    @(negedge clk); pad_in[1] = 1'b0;
    idle(5);
    check("R5 other pad ignored", pad_out[0], 1);
    @(negedge clk); pad_in[0] = 1'b0;
    idle(5);
    check("R6 pad0 pulled low wakes", pad_out[0], 0);
    rd(2'd2, d); check("R6 fall cause", d, 12'h408);
    pad_in = 2'b11;
    idle(5);
    wr(2'd3, 12'hFFF);

    // R5 rising-only
    wr(2'd1, 12'h004);
    wr(2'd0, 12'h091);
    @(negedge clk); pad_in[0] = 1'b0;
    idle(5);
    check("R5 fall not enabled", pad_out[0], 1);
    @(negedge clk); pad_in[0] = 1'b1;
    idle(5);
    check("R5 rise wakes", pad_out[0], 0);
    rd(2'd2, d); check("R5 rise cause", d, 12'h404);
    wr(2'd3, 12'hFFF);

    // R7 / R8 internal scheme, pad 1 control, polarity low
    wr(2'd0, 12'h19A);
    check("R7 pad1 idle level", pad_out[1], 1);
    check("R7 pad modes", pad_mode, 4'b0110);
    wr(2'd1, 12'h001);
    wr(2'd0, 12'h19B);
    check("R7 pad1 hib level", pad_out[1], 0);
    check("R7 pad0 not control", pad_out[0], 0);
    check("R8 reset asserted", core_rst_n, 0);
    check("R8 pull-up off", rst_pu_en, 0);
    core_pwr_ok = 1'b0;
    idle(2);
    @(negedge clk); rtc_evt = 1; @(negedge clk); rtc_evt = 0;
    check("R8 pull-up back on", rst_pu_en, 1);
    idle(3);
    check("R8 reset held", core_rst_n, 0);
    check("R3 pad1 released", pad_out[1], 1);
    @(negedge clk); core_pwr_ok = 1'b1;
    @(negedge clk);
    check("R8 reset released", core_rst_n, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule